// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the slave end of a two-wire serial bus, placed in front of a byte-wide memory array. A fast system clock samples the bus clock and data lines, and the block works out START, STOP and the bus clock edges from those samples. The master opens a transfer with a START. It then sends a select byte whose top nibble is the fixed value 1010, followed by three sub-address bits that must match the strap inputs, and a direction bit.

A write transfer carries two address bytes and then any number of data bytes. The data bytes are collected in a page buffer that holds one page of 2**PAGE_W bytes. The buffer is copied into the array only when a STOP closes the transfer cleanly, and only while the write-protect input is low. The copy and the write recovery time together form an internal write cycle. During that cycle the slave ignores its own select byte, so the master can poll for completion.

A read transfer streams bytes from the current address. The address steps after each byte. The master keeps the stream going by acknowledging, and ends it with a NoACK and a STOP. An address-only write followed by a repeated START turns the next read into a read from a chosen address.

The array holds 2**ADDR_W bytes. ADDR_W = 14 gives the full 16384-byte part, and the default of 11 keeps elaboration small. SDA is open-drain, so the block never drives it high: `sda_oe` high means the block pulls SDA low.

Top module: `serial_mem_slave`

## Requirements
- R1: After reset, and at all times when the slave is neither acknowledging nor sending a 0 bit, `sda_oe` is low.
- R2: The slave does not respond to clock or data activity on the bus until it has seen a START, which is SDA falling while SCL is high.
- R3: The slave acknowledges a select byte by holding SDA low during the 9th clock, but only when the byte, sent MSB first, is 1010 followed by `strap[2]`, `strap[1]`, `strap[0]` and a direction bit (1 = read, 0 = write). For any other select byte it leaves SDA released.
- R4: In a write transfer, the slave acknowledges both address bytes and every data byte. It does so whether or not `wp_in` is high.
- R5: In a read transfer, each byte is sent MSB first, and SDA changes only after SCL falls. The slave releases SDA during the 9th clock of each byte.
- R6: When the master acknowledges (SDA low on the 9th clock), the slave sends the byte at the next address. After a NoACK it drives nothing more until the next START.
- R7: A STOP that arrives while `wp_in` is high leaves the array unchanged.
- R8: Data bytes go to consecutive offsets within the current page and wrap from the last offset of the page to the first. The buffered bytes reach the array only when the STOP comes right after a complete acknowledged byte. A STOP in the middle of a byte discards the whole transfer.
- R9: For WR_CYCLES system clocks after a committing STOP (at least one per page byte), the slave does not acknowledge its select byte. After that time it acknowledges the select byte again.
- R10: The current address steps by one after each byte read and wraps from 2**ADDR_W-1 to 0. A read that has no address phase starts at the current address.
- R11: Address bits above ADDR_W-1 in the two-byte address (high byte first) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Sampled level of the bus clock line |
| sda_in | input | 1 | Sampled level of the bus data line |
| strap | input | 3 | Sub-address straps compared with select bits 3..1 |
| wp_in | input | 1 | Write protect; high blocks all array updates |
| sda_oe | output | 1 | High pulls the data line low (open drain) |

## Verification
The assertions assume that SDA moves while SCL is high only to form a START or a STOP. They also assume that each SCL half period is much longer than the two-stage input synchroniser, so every bus edge is seen as a separate system-clock event. They further take `wp_in` to be steady around a STOP. The bench meets all three by driving the bus in quarter-period steps of 20 system clocks, changing SDA only in the middle of the SCL low time (except for the deliberate START and STOP moves), and changing `wp_in` only while the bus is idle.

// File: rtl/sms_pkg.sv
`timescale 1ns/1ps
package sms_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SEL,
    PH_AHI,
    PH_ALO,
    PH_WDAT,
    PH_RDAT
  } phase_t;

  localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/sms_sampler.sv
`timescale 1ns/1ps
module sms_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int LINES = 2;
  localparam int L_SDA = 0;
  localparam int L_SCL = 1;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] cur;
  logic [LINES-1:0] prv;

  assign raw = {scl_in, sda_in};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [SYNC_STAGES-1:0] stg;
    logic                   dly;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg <= '1;
        dly <= 1'b1;
      end else begin
        stg <= {stg[SYNC_STAGES-2:0], raw[g]};
        dly <= stg[SYNC_STAGES-1];
      end
    end
    assign cur[g] = stg[SYNC_STAGES-1];
    assign prv[g] = dly;
  end

  assign sda_s     = cur[L_SDA];
  assign scl_rise  = cur[L_SCL] & ~prv[L_SCL];
  assign scl_fall  = ~cur[L_SCL] & prv[L_SCL];
  assign start_det = cur[L_SCL] & prv[L_SCL] & prv[L_SDA] & ~cur[L_SDA];
  assign stop_det  = cur[L_SCL] & prv[L_SCL] & ~prv[L_SDA] & cur[L_SDA];
endmodule

// File: rtl/sms_store.sv
`timescale 1ns/1ps
module sms_store #(
  parameter int ADDR_W    = 11,
  parameter int PAGE_W    = 6,
  parameter int WR_CYCLES = 2000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     buf_we,
  input  logic [PAGE_W-1:0]        buf_idx,
  input  logic [7:0]               buf_data,
  input  logic                     buf_clear,
  input  logic                     commit,
  input  logic [ADDR_W-PAGE_W-1:0] commit_page,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [7:0]               rd_data,
  output logic                     busy
);
  localparam int PAGE_N   = 1 << PAGE_W;
  localparam int DEPTH    = 1 << ADDR_W;
  localparam int PG_W     = ADDR_W - PAGE_W;
  localparam int BUSY_LEN = (WR_CYCLES > PAGE_N) ? WR_CYCLES : PAGE_N;
  localparam int CNT_W    = $clog2(BUSY_LEN + 1);

  logic [7:0]        pb  [PAGE_N];
  logic [7:0]        mem [DEPTH];
  logic [PAGE_N-1:0] vld_q,   vld_n;
  logic              walk_q,  walk_n;
  logic [PAGE_W-1:0] widx_q,  widx_n;
  logic [CNT_W-1:0]  cnt_q,   cnt_n;
  logic [PG_W-1:0]   page_q,  page_n;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_wa;

  always_comb begin
    vld_n  = vld_q;
    walk_n = walk_q;
    widx_n = widx_q;
    cnt_n  = cnt_q;
    page_n = page_q;
    if (buf_clear) vld_n = '0;
    if (buf_we)    vld_n[buf_idx] = 1'b1;
    if (commit) begin
      walk_n = 1'b1;
      widx_n = '0;
      cnt_n  = CNT_W'(BUSY_LEN);
      page_n = commit_page;
    end else begin
      if (cnt_q != '0) cnt_n = cnt_q - CNT_W'(1);
      if (walk_q) begin
        widx_n = widx_q + PAGE_W'(1);
        if (&widx_q) walk_n = 1'b0;
      end
    end
  end

  assign mem_we = walk_q & vld_q[widx_q];
  assign mem_wa = {page_q, widx_q};
  assign busy   = (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= '0;
      walk_q  <= 1'b0;
      widx_q  <= '0;
      cnt_q   <= '0;
      page_q  <= '0;
      rd_data <= '0;
    end else begin
      vld_q   <= vld_n;
      walk_q  <= walk_n;
      widx_q  <= widx_n;
      cnt_q   <= cnt_n;
      page_q  <= page_n;
      rd_data <= mem[rd_addr];
    end
  end

  always_ff @(posedge clk) begin
    if (buf_we) pb[buf_idx] <= buf_data;
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_wa] <= pb[widx_q];
  end
endmodule

// File: rtl/sms_ctrl.sv
`timescale 1ns/1ps
module sms_ctrl
  import sms_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     scl_rise,
  input  logic                     scl_fall,
  input  logic                     start_det,
  input  logic                     stop_det,
  input  logic                     sda_s,
  input  logic [2:0]               strap,
  input  logic                     wp_in,
  input  logic                     busy,
  input  logic [7:0]               rd_data,
  output logic                     sda_oe,
  output logic                     buf_we,
  output logic [PAGE_W-1:0]        buf_idx,
  output logic [7:0]               buf_data,
  output logic                     buf_clear,
  output logic                     commit,
  output logic [ADDR_W-PAGE_W-1:0] commit_page,
  output logic [ADDR_W-1:0]        cur_addr,
  output logic                     rd_step,
  output phase_t                   phase
);
  phase_t            phase_n;
  logic [3:0]        bit_q,  bit_n;
  logic              inack_q, inack_n;
  logic [6:0]        sh_q,   sh_n;
  logic [6:0]        tx_q,   tx_n;
  logic              oe_q,   oe_n;
  logic              ack_q,  ack_n;
  logic              rw_q,   rw_n;
  logic [7:0]        hi_q,   hi_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic              mack_q, mack_n;
  logic              got_q,  got_n;
  logic [7:0]        byte_in;

  assign byte_in     = {sh_q, sda_s};
  assign buf_idx     = addr_q[PAGE_W-1:0];
  assign buf_data    = byte_in;
  assign commit_page = addr_q[ADDR_W-1:PAGE_W];
  assign cur_addr    = addr_q;
  assign sda_oe      = oe_q;

  always_comb begin
    phase_n   = phase;
    bit_n     = bit_q;
    inack_n   = inack_q;
    sh_n      = sh_q;
    tx_n      = tx_q;
    oe_n      = oe_q;
    ack_n     = ack_q;
    rw_n      = rw_q;
    hi_n      = hi_q;
    addr_n    = addr_q;
    mack_n    = mack_q;
    got_n     = got_q;
    buf_we    = 1'b0;
    buf_clear = 1'b0;
    commit    = 1'b0;
    rd_step   = 1'b0;
    if (start_det) begin
      phase_n = PH_SEL;
      bit_n   = '0;
      inack_n = 1'b0;
      oe_n    = 1'b0;
    end else if (stop_det) begin
      if (phase == PH_WDAT && bit_q == 4'd1 && !inack_q && got_q && !wp_in)
        commit = 1'b1;
      phase_n = PH_IDLE;
      bit_n   = '0;
      inack_n = 1'b0;
      oe_n    = 1'b0;
    end else if (phase != PH_IDLE) begin
      if (scl_rise) begin
        if (inack_q) begin
          mack_n = ~sda_s;
        end else if (bit_q != 4'd8) begin
          bit_n = bit_q + 4'd1;
          sh_n  = byte_in[6:0];
          if (bit_q == 4'd7) begin
            ack_n = 1'b1;
            case (phase)
              PH_SEL: begin
                ack_n = (byte_in[7:1] == {DEV_TYPE, strap}) && !busy;
                rw_n  = byte_in[0];
              end
              PH_AHI:  hi_n   = byte_in;
              PH_ALO:  addr_n = ADDR_W'({hi_q, byte_in});
              PH_WDAT: begin
                buf_we = 1'b1;
                got_n  = 1'b1;
                addr_n = {addr_q[ADDR_W-1:PAGE_W], addr_q[PAGE_W-1:0] + PAGE_W'(1)};
              end
              default: ack_n = 1'b0;
            endcase
          end
        end
      end else if (scl_fall) begin
        if (inack_q) begin
          inack_n = 1'b0;
          bit_n   = '0;
          oe_n    = 1'b0;
          case (phase)
            PH_SEL: begin
              if (!ack_q) phase_n = PH_IDLE;
              else if (rw_q) begin
                phase_n = PH_RDAT;
                tx_n    = rd_data[6:0];
                oe_n    = ~rd_data[7];
              end else phase_n = PH_AHI;
            end
            PH_AHI: phase_n = PH_ALO;
            PH_ALO: begin
              phase_n   = PH_WDAT;
              buf_clear = 1'b1;
              got_n     = 1'b0;
            end
            PH_RDAT: begin
              if (mack_q) begin
                tx_n = rd_data[6:0];
                oe_n = ~rd_data[7];
              end else phase_n = PH_IDLE;
            end
            default: ;
          endcase
        end else if (bit_q == 4'd8) begin
          inack_n = 1'b1;
          if (phase == PH_RDAT) begin
            oe_n    = 1'b0;
            rd_step = 1'b1;
            addr_n  = addr_q + ADDR_W'(1);
          end else begin
            oe_n = ack_q;
          end
        end else if (phase == PH_RDAT && bit_q != 4'd0) begin
          tx_n = {tx_q[5:0], 1'b0};
          oe_n = ~tx_q[6];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      bit_q   <= '0;
      inack_q <= 1'b0;
      sh_q    <= '0;
      tx_q    <= '0;
      oe_q    <= 1'b0;
      ack_q   <= 1'b0;
      rw_q    <= 1'b0;
      hi_q    <= '0;
      addr_q  <= '0;
      mack_q  <= 1'b0;
      got_q   <= 1'b0;
    end else begin
      phase   <= phase_n;
      bit_q   <= bit_n;
      inack_q <= inack_n;
      sh_q    <= sh_n;
      tx_q    <= tx_n;
      oe_q    <= oe_n;
      ack_q   <= ack_n;
      rw_q    <= rw_n;
      hi_q    <= hi_n;
      addr_q  <= addr_n;
      mack_q  <= mack_n;
      got_q   <= got_n;
    end
  end
endmodule

// File: rtl/serial_mem_slave.sv
`timescale 1ns/1ps
module serial_mem_slave
  import sms_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int PAGE_W      = 6,
  parameter int WR_CYCLES   = 2000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic [2:0] strap,
  input  logic       wp_in,
  output logic       sda_oe
);
  localparam int PG_W = ADDR_W - PAGE_W;

  logic [1:0]        rst_sync;
  logic              rst_int_n;
  logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              buf_we, buf_clear, commit, busy, rd_step;
  logic [PAGE_W-1:0] buf_idx;
  logic [7:0]        buf_data, rd_data;
  logic [PG_W-1:0]   commit_page;
  logic [ADDR_W-1:0] cur_addr;
  phase_t            phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  sms_sampler #(.SYNC_STAGES(SYNC_STAGES)) i_sampler (
    .clk(clk), .rst_n(rst_int_n), .scl_in(scl_in), .sda_in(sda_in),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  sms_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) i_ctrl (
    .clk(clk), .rst_n(rst_int_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s), .strap(strap),
    .wp_in(wp_in), .busy(busy), .rd_data(rd_data), .sda_oe(sda_oe),
    .buf_we(buf_we), .buf_idx(buf_idx), .buf_data(buf_data),
    .buf_clear(buf_clear), .commit(commit), .commit_page(commit_page),
    .cur_addr(cur_addr), .rd_step(rd_step), .phase(phase)
  );

  sms_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) i_store (
    .clk(clk), .rst_n(rst_int_n), .buf_we(buf_we), .buf_idx(buf_idx),
    .buf_data(buf_data), .buf_clear(buf_clear), .commit(commit),
    .commit_page(commit_page), .rd_addr(cur_addr), .rd_data(rd_data),
    .busy(busy)
  );
endmodule

// File: rtl/sms_checker.sv
`timescale 1ns/1ps
module sms_checker
  import sms_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sda_oe,
  input logic              wp_in,
  input logic              scl_fall,
  input logic              start_det,
  input logic              stop_det,
  input logic              commit,
  input logic              busy,
  input logic              rd_step,
  input logic [ADDR_W-1:0] cur_addr,
  input phase_t            phase
);
  AST_OE_MOVES_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> $past(scl_fall || start_det || stop_det)); // R5

  AST_NO_COMMIT_PROTECTED: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !wp_in); // R7

  AST_BUSY_NO_SESSION: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (phase != PH_AHI && phase != PH_ALO && phase != PH_WDAT && phase != PH_RDAT)); // R9

  AST_READ_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    rd_step |=> cur_addr == $past(cur_addr) + ADDR_W'(1)); // R10

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && !scl_fall && !start_det) |=> !sda_oe); // R1
endmodule

bind serial_mem_slave sms_checker #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst_n(rst_int_n), .sda_oe(sda_oe), .wp_in(wp_in),
  .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
  .commit(commit), .busy(busy), .rd_step(rd_step), .cur_addr(cur_addr),
  .phase(phase)
);

// File: tb/test_serial_mem_slave.sv
`timescale 1ns/1ps
module test_serial_mem_slave;
  localparam int AW = 11;
  localparam int WC = 2000;
  localparam int Q  = 20;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] SELW = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] SELR = {4'b1010, STRAP, 1'b1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic wp = 1'b0;
  logic sda_oe;
  wire  sda_line = sda_m & ~sda_oe;
  int   n_cmp = 0;
  int   n_bad = 0;

  always #2.5 clk = ~clk;

  serial_mem_slave #(.ADDR_W(AW), .PAGE_W(6), .WR_CYCLES(WC), .SYNC_STAGES(2)) i_serial_mem_slave (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line),
    .strap(STRAP), .wp_in(wp), .sda_oe(sda_oe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qwait(); scl = 1'b1; qwait(); sda_m = 1'b0; qwait(); scl = 1'b0; qwait();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qwait(); scl = 1'b1; qwait(); sda_m = 1'b1; qwait();
  endtask

  task automatic bit_x(input logic b, output logic r);
    sda_m = b; qwait(); scl = 1'b1; qwait(); r = sda_line; qwait(); scl = 1'b0; qwait();
  endtask

  task automatic wr_byte(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_x(d[i], r);
    bit_x(1'b1, r);
    ack = ~r;
  endtask

  task automatic rd_byte(input logic mack, output logic [7:0] d, output logic rel);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bit_x(1'b1, r);
      d[i] = r;
    end
    bit_x(~mack, r);
    rel = r;
  endtask

  task automatic write_seq(input logic [15:0] a, input int n, input logic [31:0] data, output logic ok);
    logic ak;
    bus_start();
    wr_byte(SELW, ak); ok = ak;
    wr_byte(a[15:8], ak); ok = ok & ak;
    wr_byte(a[7:0], ak); ok = ok & ak;
    for (int k = 0; k < n; k++) begin
      wr_byte(data[31-8*k -: 8], ak);
      ok = ok & ak;
    end
    bus_stop();
  endtask

  task automatic read_seq(input logic [15:0] a, input int n, output logic [31:0] data, output logic rel);
    logic ak;
    logic [7:0] d;
    bus_start();
    wr_byte(SELW, ak); wr_byte(a[15:8], ak); wr_byte(a[7:0], ak);
    bus_start();
    wr_byte(SELR, ak);
    data = '0;
    rel = 1'b0;
    for (int k = 0; k < n; k++) begin
      rd_byte(k != n - 1, d, rel);
      data = {data[23:0], d};
    end
  endtask

  task automatic wait_wc();
    repeat (WC + 200) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 sda_oe released after reset", sda_oe, 1'b0);
  endtask

  task automatic t_nostart();
    logic r;
    scl = 1'b0; qwait();
    for (int i = 7; i >= 0; i--) bit_x(SELW[i], r);
    bit_x(1'b1, r);
    chk("R2 no ack without START", r, 1'b1);
    bus_stop();
    chk("R1 released after stray traffic", sda_oe, 1'b0);
  endtask

  task automatic t_badsel();
    logic ak;
    bus_start(); wr_byte({4'b1010, 3'b100, 1'b0}, ak); bus_stop();
    chk("R3 strap mismatch no ack", ak, 1'b0);
    bus_start(); wr_byte({4'b1011, STRAP, 1'b0}, ak); bus_stop();
    chk("R3 type mismatch no ack", ak, 1'b0);
    bus_start(); wr_byte(SELW, ak); bus_stop();
    chk("R3 matching select acked", ak, 1'b1);
  endtask

  task automatic t_write_poll_read();
    logic ok, ak, rel, r;
    logic [31:0] d;
    write_seq(16'h0010, 4, 32'h11223344, ok);
    chk("R4 address and data acked", ok, 1'b1);
    bus_start(); wr_byte(SELW, ak); bus_stop();
    chk("R9 select ignored during write cycle", ak, 1'b0);
    wait_wc();
    bus_start(); wr_byte(SELW, ak); bus_stop();
    chk("R9 select acked after write cycle", ak, 1'b1);
    read_seq(16'h0010, 4, d, rel);
    chk("R5 R6 sequential read data", d, 32'h11223344);
    chk("R5 released on 9th clock after NoACK", rel, 1'b1);
    bit_x(1'b1, r);
    chk("R6 nothing driven after NoACK", r, 1'b1);
    bus_stop();
  endtask

  task automatic t_page_wrap();
    logic ok, rel;
    logic [31:0] d;
    write_seq(16'h07FE, 4, 32'h55667788, ok);
    wait_wc();
    read_seq(16'h07FE, 2, d, rel); bus_stop();
    chk("R8 bytes before page end", d, 32'h00005566);
    read_seq(16'h07C0, 2, d, rel); bus_stop();
    chk("R8 bytes wrapped to page start", d, 32'h00007788);
  endtask

  task automatic t_top_wrap();
    logic ok, rel;
    logic [31:0] d;
    write_seq(16'h0000, 1, 32'hA5000000, ok);
    wait_wc();
    read_seq(16'h07FF, 2, d, rel); bus_stop();
    chk("R10 read wraps from top to address 0", d, 32'h000066A5);
  endtask

  task automatic t_current();
    logic ak, rel;
    logic [7:0] b;
    logic [31:0] d;
    read_seq(16'h0010, 1, d, rel); bus_stop();
    chk("R10 random read byte", d, 32'h00000011);
    bus_start(); wr_byte(SELR, ak); rd_byte(1'b0, b, rel); bus_stop();
    chk("R10 current address read continues", b, 8'h22);
  endtask

  task automatic t_protect();
    logic ok, rel;
    logic [31:0] d;
    wp = 1'b1;
    repeat (10) @(negedge clk);
    write_seq(16'h0010, 1, 32'h99000000, ok);
    chk("R4 data acked while protected", ok, 1'b1);
    wait_wc();
    wp = 1'b0;
    read_seq(16'h0010, 1, d, rel); bus_stop();
    chk("R7 protected write left array unchanged", d, 32'h00000011);
  endtask

  task automatic t_abort();
    logic ak, r, rel;
    logic [31:0] d;
    bus_start();
    wr_byte(SELW, ak); wr_byte(8'h00, ak); wr_byte(8'h11, ak);
    wr_byte(8'h77, ak);
    bit_x(1'b1, r); bit_x(1'b0, r); bit_x(1'b1, r);
    bus_stop();
    wait_wc();
    read_seq(16'h0011, 1, d, rel); bus_stop();
    chk("R8 STOP mid-byte discards transfer", d, 32'h00000022);
  endtask

  task automatic t_high_bits();
    logic rel;
    logic [31:0] d;
    read_seq(16'hF810, 1, d, rel); bus_stop();
    chk("R11 upper address bits ignored", d, 32'h00000011);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    t_reset();
    t_nostart();
    t_badsel();
    t_write_poll_read();
    t_page_wrap();
    t_top_wrap();
    t_current();
    t_protect();
    t_abort();
    t_high_bits();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule